// File: doc/BRIEF.md
# Dual-Issue Hazard Checker

This block is the issue-stage hazard logic of an in-order, two-wide pipeline. In each cycle it receives two decoded instructions in program order, called slot 0 (older) and slot 1 (younger). Each instruction has a valid bit, a destination register, two source registers, a functional-unit class, an execution latency and a branch flag. The block decides whether each slot may issue in this cycle. It also reports a stall reason for each slot: 0 none, 1 read-after-write, 2 write-after-write, 3 write-after-read, 4 unit conflict, 5 branch boundary, 6 held behind slot 0.

The block keeps two kinds of state. A scoreboard holds one remaining-cycle counter for each architectural register. A busy counter tracks each of the three non-pipelined execution units. An issued writer with latency L (a value of 0 counts as 1) writes back at the end of its L-th cycle. Its unit stays occupied for the same L cycles. The block compares each slot against this in-flight state. It also compares slot 1 against slot 0, because both may issue together.

Register 0 is a constant and never takes part in a dependency. A destination of 0 means the instruction writes nothing, and a source of 0 means the operand is not used.

Top module: `dual_issue_hazard_check`

## Requirements
- R1: While rst_n is low, neither slot issues. After reset the scoreboard and unit counters are clear, so two valid instructions with no mutual conflict both issue in the first cycle.
- R2: A writer of register r issued with latency L (L=0 counts as 1) blocks any reader of r for the next L-1 cycles with reason 1. The reader issues in the L-th cycle after the writer's issue cycle.
- R3: A slot whose destination still has k remaining cycles pending stalls with reason 2 while k >= its own effective latency. It issues as soon as its latency exceeds k, so that it writes back strictly after the older write.
- R4: An instruction issued with latency L makes its unit (class 0..2) busy for the next L-1 cycles. A later instruction of that class, in either slot, stalls with reason 4 during that time.
- R5: If slot 1 reads a register that slot 0 writes, slot 1 stalls with reason 1 while slot 0 issues.
- R6: If both slots write the same register, slot 1 stalls with reason 2.
- R7: If slot 1 writes a register that slot 0 reads, slot 1 stalls with reason 3.
- R8: If both slots name the same unit class in the range 0..2, slot 1 stalls with reason 4. Unit class 3 means no unit and never conflicts.
- R9: If slot 0 has its branch flag set, slot 1 stalls with reason 5. A branch in slot 1 does not stop slot 1 from issuing with slot 0.
- R10: Slot 1 never issues unless slot 0 issues in the same cycle. A valid slot 1 behind a slot 0 that is stalled or invalid reports reason 6.
- R11: Register 0 never causes a stall as a source or destination, and writing it never leaves a pending entry.
- R12: When several hazards apply to slot 1, the reported reason is the first match in the order 6, 5, 1, 2, 3, 4. For slot 0 the order is 1, 2, 4.
- R13: An invalid slot has issue low and reason 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_dst | input | 5 | Slot 0 destination register (0 = no write) |
| s0_src_a | input | 5 | Slot 0 first source register |
| s0_src_b | input | 5 | Slot 0 second source register |
| s0_unit | input | 2 | Slot 0 unit class (3 = none) |
| s0_lat | input | 3 | Slot 0 latency in cycles (0 counts as 1) |
| s0_branch | input | 1 | Slot 0 is a conditional branch |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_dst | input | 5 | Slot 1 destination register |
| s1_src_a | input | 5 | Slot 1 first source register |
| s1_src_b | input | 5 | Slot 1 second source register |
| s1_unit | input | 2 | Slot 1 unit class |
| s1_lat | input | 3 | Slot 1 latency |
| s1_branch | input | 1 | Slot 1 is a conditional branch |
| issue0 | output | 1 | Slot 0 issues this cycle |
| issue1 | output | 1 | Slot 1 issues this cycle |
| reason0 | output | 3 | Slot 0 stall reason |
| reason1 | output | 3 | Slot 1 stall reason |

## Verification
The bench counts the exact stall window after a three-cycle writer. An off-by-one scoreboard would either release the reader one cycle early or hold it one cycle too long. For write-after-write, it probes the point where the new latency just exceeds the pending count. A wrong comparison would let a short write overtake a long one, or would stall it for no reason. Slot 1 is given combined hazards to pin the reason priority. The bench also covers a slot 1 behind an invalid slot 0, a branch in either slot, unit class 3 in both slots, and register 0 in every position. Each of these catches a design that issues out of order, splits a group across a branch, or lets register 0 create false dependencies. A reset while a writer is in flight checks that no stale pending entry survives.

// File: rtl/dual_issue_hazard_check.sv
module dual_issue_hazard_check #(
  parameter int NREG  = 32,
  parameter int NUNIT = 3,
  parameter int LATW  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s0_valid,
  input  logic [$clog2(NREG)-1:0]  s0_dst,
  input  logic [$clog2(NREG)-1:0]  s0_src_a,
  input  logic [$clog2(NREG)-1:0]  s0_src_b,
  input  logic [$clog2(NUNIT+1)-1:0] s0_unit,
  input  logic [LATW-1:0]          s0_lat,
  input  logic                     s0_branch,
  input  logic                     s1_valid,
  input  logic [$clog2(NREG)-1:0]  s1_dst,
  input  logic [$clog2(NREG)-1:0]  s1_src_a,
  input  logic [$clog2(NREG)-1:0]  s1_src_b,
  input  logic [$clog2(NUNIT+1)-1:0] s1_unit,
  input  logic [LATW-1:0]          s1_lat,
  input  logic                     s1_branch,
  output logic                     issue0,
  output logic                     issue1,
  output logic [2:0]               reason0,
  output logic [2:0]               reason1
);
  localparam int RW = $clog2(NREG);
  localparam int UW = $clog2(NUNIT+1);
  localparam int UPAD = 1 << UW;
  localparam logic [UW-1:0] ULIM = UW'(NUNIT);
  localparam logic [2:0] RS_NONE = 3'd0, RS_RAW = 3'd1, RS_WAW = 3'd2,
                         RS_WAR = 3'd3, RS_RES = 3'd4, RS_BR = 3'd5, RS_HOLD = 3'd6;

  logic [LATW-1:0] pend [NREG];
  logic [LATW-1:0] ubusy [NUNIT];
  logic [UPAD-1:0] unit_taken;

  for (genvar u = 0; u < UPAD; u++) begin : g_taken
    if (u < NUNIT) begin : g_real
      assign unit_taken[u] = ubusy[u] != '0;
    end else begin : g_none
      assign unit_taken[u] = 1'b0;
    end
  end

  wire [LATW-1:0] lat0 = (s0_lat == '0) ? LATW'(1) : s0_lat;
  wire [LATW-1:0] lat1 = (s1_lat == '0) ? LATW'(1) : s1_lat;

  wire raw0 = (s0_src_a != '0 && pend[s0_src_a] != '0) ||
              (s0_src_b != '0 && pend[s0_src_b] != '0);
  wire waw0 = s0_dst != '0 && pend[s0_dst] >= lat0;
  wire res0 = unit_taken[s0_unit];

  wire raw1 = (s1_src_a != '0 && pend[s1_src_a] != '0) ||
              (s1_src_b != '0 && pend[s1_src_b] != '0);
  wire waw1 = s1_dst != '0 && pend[s1_dst] >= lat1;
  wire res1 = unit_taken[s1_unit];

  wire wr0    = s0_dst != '0;
  wire raw_x  = wr0 && (s1_src_a == s0_dst || s1_src_b == s0_dst);
  wire waw_x  = wr0 && s1_dst == s0_dst;
  wire war_x  = s1_dst != '0 && (s1_dst == s0_src_a || s1_dst == s0_src_b);
  wire res_x  = s0_unit < ULIM && s0_unit == s1_unit;

  always_comb begin
    if (!s0_valid)  reason0 = RS_NONE;
    else if (raw0)  reason0 = RS_RAW;
    else if (waw0)  reason0 = RS_WAW;
    else if (res0)  reason0 = RS_RES;
    else            reason0 = RS_NONE;
  end

  assign issue0 = rst_n && s0_valid && reason0 == RS_NONE;

  always_comb begin
    if (!s1_valid)            reason1 = RS_NONE;
    else if (!issue0)         reason1 = RS_HOLD;
    else if (s0_branch)       reason1 = RS_BR;
    else if (raw1 || raw_x)   reason1 = RS_RAW;
    else if (waw1 || waw_x)   reason1 = RS_WAW;
    else if (war_x)           reason1 = RS_WAR;
    else if (res1 || res_x)   reason1 = RS_RES;
    else                      reason1 = RS_NONE;
  end

  assign issue1 = rst_n && s1_valid && reason1 == RS_NONE;

  for (genvar r = 0; r < NREG; r++) begin : g_sb
    always_ff @(posedge clk) begin
      if (!rst_n)
        pend[r] <= '0;
      else if (r != 0 && issue0 && s0_dst == RW'(r))
        pend[r] <= lat0 - LATW'(1);
      else if (r != 0 && issue1 && s1_dst == RW'(r))
        pend[r] <= lat1 - LATW'(1);
      else if (pend[r] != '0)
        pend[r] <= pend[r] - LATW'(1);
    end
  end

  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    always_ff @(posedge clk) begin
      if (!rst_n)
        ubusy[u] <= '0;
      else if (issue0 && s0_unit == UW'(u))
        ubusy[u] <= lat0 - LATW'(1);
      else if (issue1 && s1_unit == UW'(u))
        ubusy[u] <= lat1 - LATW'(1);
      else if (ubusy[u] != '0)
        ubusy[u] <= ubusy[u] - LATW'(1);
    end
  end

  AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    issue1 |-> issue0); // R10
  AST_BRANCH_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue0 && s0_branch) |-> !issue1); // R9
  AST_UNIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue0 && issue1 && s0_unit < ULIM) |-> s1_unit != s0_unit); // R8
  AST_RAW_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (issue0 && s0_dst != '0 && s0_lat == LATW'(2)) |=>
      !(issue0 && (s0_src_a == $past(s0_dst) || s0_src_b == $past(s0_dst)))); // R2
  AST_UNIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (issue0 && s0_unit < ULIM && s0_lat == LATW'(2)) |=>
      !(issue0 && s0_unit == $past(s0_unit))); // R4
  AST_R0_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] == '0); // R11
endmodule

// File: tb/dual_issue_hazard_check_test.sv
module dual_issue_hazard_check_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [21:0] sl0 = '0, sl1 = '0;
  logic issue0, issue1;
  logic [2:0] reason0, reason1;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  dual_issue_hazard_check uut (
    .clk(clk), .rst_n(rst_n),
    .s0_valid(sl0[21]), .s0_dst(sl0[20:16]), .s0_src_a(sl0[15:11]), .s0_src_b(sl0[10:6]),
    .s0_unit(sl0[5:4]), .s0_lat(sl0[3:1]), .s0_branch(sl0[0]),
    .s1_valid(sl1[21]), .s1_dst(sl1[20:16]), .s1_src_a(sl1[15:11]), .s1_src_b(sl1[10:6]),
    .s1_unit(sl1[5:4]), .s1_lat(sl1[3:1]), .s1_branch(sl1[0]),
    .issue0(issue0), .issue1(issue1), .reason0(reason0), .reason1(reason1));

  function automatic logic [21:0] ins(input int d, a, b, u, l, br);
    return {1'b1, 5'(d), 5'(a), 5'(b), 2'(u), 3'(l), 1'(br)};
  endfunction

  localparam logic [21:0] NOP = 22'd0;
  localparam int NV = 17;
  // {slot0, slot1, exp issue0, exp issue1, exp reason0, exp reason1, requirement}
  localparam logic [55:0] VEC [NV] = '{
    {ins(1,2,3,0,1,0), ins(4,5,6,1,1,0), 1'b1, 1'b1, 3'd0, 3'd0, 4'd1},   // R1
    {ins(1,2,3,0,1,0), ins(4,1,6,1,1,0), 1'b1, 1'b0, 3'd0, 3'd1, 4'd5},   // R5
    {ins(1,2,3,0,1,0), ins(4,6,1,1,1,0), 1'b1, 1'b0, 3'd0, 3'd1, 4'd5},   // R5
    {ins(7,2,3,0,1,0), ins(7,5,6,1,1,0), 1'b1, 1'b0, 3'd0, 3'd2, 4'd6},   // R6
    {ins(8,9,3,0,1,0), ins(9,5,6,1,1,0), 1'b1, 1'b0, 3'd0, 3'd3, 4'd7},   // R7
    {ins(8,3,9,0,1,0), ins(9,5,6,1,1,0), 1'b1, 1'b0, 3'd0, 3'd3, 4'd7},   // R7
    {ins(1,2,3,2,1,0), ins(4,5,6,2,1,0), 1'b1, 1'b0, 3'd0, 3'd4, 4'd8},   // R8
    {ins(1,2,3,3,1,0), ins(4,5,6,3,1,0), 1'b1, 1'b1, 3'd0, 3'd0, 4'd8},   // R8
    {ins(0,2,3,0,1,1), ins(4,5,6,1,1,0), 1'b1, 1'b0, 3'd0, 3'd5, 4'd9},   // R9
    {ins(1,2,3,0,1,0), ins(0,5,6,1,1,1), 1'b1, 1'b1, 3'd0, 3'd0, 4'd9},   // R9
    {ins(0,2,3,0,1,0), ins(0,0,0,1,1,0), 1'b1, 1'b1, 3'd0, 3'd0, 4'd11},  // R11
    {ins(1,2,3,0,1,1), ins(4,1,6,0,1,0), 1'b1, 1'b0, 3'd0, 3'd5, 4'd12},  // R12
    {ins(1,2,3,0,1,0), ins(1,1,6,0,1,0), 1'b1, 1'b0, 3'd0, 3'd1, 4'd12},  // R12
    {ins(7,7,3,0,1,0), ins(7,5,6,0,1,0), 1'b1, 1'b0, 3'd0, 3'd2, 4'd12},  // R12
    {ins(8,9,3,0,1,0), ins(9,5,6,0,1,0), 1'b1, 1'b0, 3'd0, 3'd3, 4'd12},  // R12
    {NOP,              ins(4,5,6,1,1,0), 1'b0, 1'b0, 3'd0, 3'd6, 4'd10},  // R10
    {ins(1,2,3,0,1,0), NOP,              1'b1, 1'b0, 3'd0, 3'd0, 4'd13}   // R13
  };

  task automatic step(input logic [21:0] a, input logic [21:0] b,
                      input logic ei0, input logic ei1,
                      input logic [2:0] er0, input logic [2:0] er1, input string tag);
    @(negedge clk);
    sl0 = a;
    sl1 = b;
    #1;
    tests++;
    if (issue0 !== ei0 || issue1 !== ei1 || reason0 !== er0 || reason1 !== er1) begin
      fails++;
      $display("FAIL %s: issue0=%b issue1=%b reason0=%0d reason1=%0d, expected %b %b %0d %0d",
               tag, issue0, issue1, reason0, reason1, ei0, ei1, er0, er1);
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      sl0 = NOP;
      sl1 = NOP;
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: no issue while in reset, even with valid input
    step(ins(1,2,3,0,1,0), NOP, 1'b0, 1'b0, 3'd0, 3'd0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    drain();

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][55:34], VEC[k][33:12], VEC[k][11], VEC[k][10], VEC[k][9:7], VEC[k][6:4],
           $sformatf("R%0d", VEC[k][3:0]));
      drain();
    end

    // R2: three-cycle writer, reader waits two cycles; R10 slot 1 held behind it
    step(ins(5,1,2,0,3,0), NOP, 1'b1, 1'b0, 3'd0, 3'd0, "R2");
    step(ins(6,5,0,1,1,0), ins(10,11,12,2,1,0), 1'b0, 1'b0, 3'd1, 3'd6, "R2");
    step(ins(6,5,0,1,1,0), NOP, 1'b0, 1'b0, 3'd1, 3'd0, "R2");
    step(ins(6,5,0,1,1,0), NOP, 1'b1, 1'b0, 3'd0, 3'd0, "R2");
    drain();
    // R2: latency 0 behaves as 1, no in-flight stall
    step(ins(5,1,2,0,0,0), NOP, 1'b1, 1'b0, 3'd0, 3'd0, "R2");
    step(ins(6,5,0,1,1,0), NOP, 1'b1, 1'b0, 3'd0, 3'd0, "R2");
    drain();
    // R2: in-flight read hazard seen by slot 1
    step(ins(5,1,2,0,3,0), NOP, 1'b1, 1'b0, 3'd0, 3'd0, "R2");
    step(ins(7,0,0,1,1,0), ins(8,0,5,2,1,0), 1'b1, 1'b0, 3'd0, 3'd1, "R2");
    drain();
    // R3: pending 3 versus new latency 2 stalls until pending drops to 1
    step(ins(5,1,2,0,4,0), NOP, 1'b1, 1'b0, 3'd0, 3'd0, "R3");
    step(ins(5,0,0,1,2,0), NOP, 1'b0, 1'b0, 3'd2, 3'd0, "R3");
    step(ins(5,0,0,1,2,0), NOP, 1'b0, 1'b0, 3'd2, 3'd0, "R3");
    step(ins(5,0,0,1,2,0), NOP, 1'b1, 1'b0, 3'd0, 3'd0, "R3");
    drain();
    // R3: longer latency than pending count issues at once
    step(ins(5,1,2,0,4,0), NOP, 1'b1, 1'b0, 3'd0, 3'd0, "R3");
    step(ins(5,0,0,1,5,0), NOP, 1'b1, 1'b0, 3'd0, 3'd0, "R3");
    drain();
    // R4: two-cycle op holds its unit for one more cycle
    step(ins(1,2,3,2,2,0), NOP, 1'b1, 1'b0, 3'd0, 3'd0, "R4");
    step(ins(4,5,6,2,1,0), NOP, 1'b0, 1'b0, 3'd4, 3'd0, "R4");
    step(ins(4,5,6,2,1,0), NOP, 1'b1, 1'b0, 3'd0, 3'd0, "R4");
    drain();
    step(ins(1,2,3,2,2,0), NOP, 1'b1, 1'b0, 3'd0, 3'd0, "R4");
    step(ins(7,0,0,0,1,0), ins(4,5,6,2,1,0), 1'b1, 1'b0, 3'd0, 3'd4, "R4");
    drain();
    // R11: writing register 0 with long latency leaves nothing pending
    step(ins(0,1,2,0,3,0), NOP, 1'b1, 1'b0, 3'd0, 3'd0, "R11");
    step(ins(0,0,0,1,1,0), ins(6,0,0,2,1,0), 1'b1, 1'b1, 3'd0, 3'd0, "R11");
    drain();
    // R13: both slots empty
    step(NOP, NOP, 1'b0, 1'b0, 3'd0, 3'd0, "R13");
    // R1: reset while a writer is in flight clears the scoreboard
    step(ins(9,1,2,0,5,0), NOP, 1'b1, 1'b0, 3'd0, 3'd0, "R1");
    @(negedge clk);
    sl0 = NOP;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(ins(10,9,0,0,1,0), ins(11,0,0,1,1,0), 1'b1, 1'b1, 3'd0, 3'd0, "R1");
    drain();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule